// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Capture Strobe

This block presents a five-digit decimal result one digit at a time. It takes a stored result (five 4-bit BCD digits), an overrange flag and a one-cycle end-of-conversion pulse. It then drives five positive digit-select lines and a shared 4-bit BCD bus. The digits are scanned from the most significant to the least significant and then repeat, so a multiplexed display stays refreshed between conversions.

On the first scan after each new result, the block sends one active-low strobe pulse, half a clock long, near the middle of each digit slot. A UART, processor or external latch can use these pulses to pick up each digit exactly once. The most significant slot is one clock longer than the others.

When the result is out of range, the bus reads zero. After the last strobe the select lines go dark and stay dark until a start-of-reference-integrate pulse arrives. Scanning then resumes, so a display connected to the block blinks.

Top module: `bcd_digit_scanner`

## Requirements
- R1: After a synchronous active-low reset, and until the first end-of-conversion pulse, `dsel` is all zero, `bcd` is zero and `strobe_n` is high.
- R2: An end-of-conversion pulse sampled on a clock edge stores `digits_in` and `ovr_in`. From the next cycle on, the most significant select line `dsel[4]` is high.
- R3: Exactly one select line is high while scanning. The order is `dsel[4]` (most significant), then `dsel[3]`, `dsel[2]`, `dsel[1]`, `dsel[0]` (least significant), and then back to `dsel[4]`. Scanning continues indefinitely.
- R4: The slot of `dsel[4]` lasts 201 clock cycles. Every other slot lasts 200 cycles.
- R5: While `dsel[k]` is high, `bcd` carries stored bits `digits_in[4k+3:4k]` (positive-true). `bcd` changes in the same cycle as `dsel`. When no select line is high, `bcd` is zero.
- R6: On the first scan after a result is stored, `strobe_n` goes low during the low half of one clock cycle in each slot. Counting the slot's first cycle as 0, that is cycle 101 of the `dsel[4]` slot and cycle 100 of each other slot. This gives five strobes per result.
- R7: Later scans of the same result produce no strobe.
- R8: An end-of-conversion pulse during a scan restarts the scan at `dsel[4]` with the new digits. It also re-arms all five strobes.
- R9: While the stored overrange flag is set, `bcd` reads zero in every slot. A new result with the flag clear restores the digit values.
- R10: With the overrange flag set, all select lines go low from the cycle after the fifth strobe. They stay low until a `ref_start` pulse. In the cycle after that pulse, scanning restarts at `dsel[4]`, without strobes.
- R11: A `ref_start` pulse while the lines are not blanked has no effect on `dsel`, `bcd` or `strobe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the low phase shapes the strobe |
| rst_n | input | 1 | Synchronous active-low reset |
| eoc | input | 1 | One-cycle end-of-conversion pulse; stores a new result |
| ovr_in | input | 1 | Overrange flag of the result offered with `eoc` |
| digits_in | input | 20 | Five BCD digits; digit k (k=0 least significant) in bits 4k+3:4k |
| ref_start | input | 1 | Start-of-reference-integrate pulse; ends overrange blanking |
| dsel | output | 5 | One-hot digit select; bit 4 is the most significant digit |
| bcd | output | 4 | BCD value of the selected digit |
| strobe_n | output | 1 | Active-low half-clock capture strobe |

## Verification
The hardest state to reach from the ports is overrange blanking. It takes a stored overrange result, a full first scan up to the fifth strobe, and then a separate `ref_start` pulse at a chosen time. The stimulus stores an out-of-range result and checks every cycle through the blanked stretch. It then sends `ref_start` and follows the resumed scan, which has no strobes. A further pulse is sent in the middle of a normal scan to show that it is ignored. A second result is stored halfway through a scan to exercise the restart and re-arm.

// File: rtl/dscan_pkg.sv
// Shared types and slot arithmetic for the BCD digit scanner.
// Assumes: digits are 4-bit BCD values; slot counters are unsigned.
package dscan_pkg;
    typedef logic [3:0] bcd_t;

    // Cycle index of the strobe inside a slot; the leading slot is one longer.
    function automatic int unsigned strobe_pos(input bit lead, input int unsigned ofs);
        return lead ? ofs + 1 : ofs;
    endfunction
endpackage

// File: rtl/dscan_timer.sv
// Slot timer: walks the digit index from the top digit down to digit 0 and
// wraps back to the top. The top slot lasts SLOT+1 cycles, the others SLOT.
// A restart puts it on the top slot, cycle 0. Hold freezes it.
// Assumes: OFS+1 < SLOT.
module dscan_timer
    import dscan_pkg::*;
#(
    parameter int N    = 5,
    parameter int SLOT = 200,
    parameter int OFS  = 100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 hold,
    output logic [$clog2(N)-1:0] idx,
    output logic                 active,
    output logic                 hit
);
    localparam int IW = $clog2(N);
    localparam int CW = $clog2(SLOT + 1);
    localparam logic [IW-1:0] TOP      = IW'(N - 1);
    localparam logic [CW-1:0] LAST_TOP = CW'(SLOT);
    localparam logic [CW-1:0] LAST_REG = CW'(SLOT - 1);
    localparam logic [CW-1:0] HIT_TOP  = CW'(strobe_pos(1'b1, OFS));
    localparam logic [CW-1:0] HIT_REG  = CW'(strobe_pos(1'b0, OFS));

    logic [CW-1:0] cnt;
    logic          at_top;

    assign at_top = (idx == TOP);

    // Advance the in-slot count and step the digit index at each slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            cnt    <= '0;
            active <= 1'b0;
        end else if (restart) begin
            idx    <= TOP;
            cnt    <= '0;
            active <= 1'b1;
        end else if (active && !hold) begin
            if (cnt == (at_top ? LAST_TOP : LAST_REG)) begin
                cnt <= '0;
                idx <= (idx == '0) ? TOP : idx - 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Flag the strobe position inside the current slot.
    always_comb begin
        hit = active && !hold && (cnt == (at_top ? HIT_TOP : HIT_REG));
    end
endmodule

// File: rtl/dscan_strobe.sv
// Strobe arming: a new result arms five strobes; the strobe in the last
// digit slot disarms. Assumes hit is high for one cycle per slot.
module dscan_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic hit,
    input  logic last_digit,
    output logic strobe_cyc,
    output logic done
);
    logic armed;

    // Hold the armed flag from a new result until the final strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (arm) begin
            armed <= 1'b1;
        end else if (hit && last_digit) begin
            armed <= 1'b0;
        end
    end

    // Qualify the slot position with the armed flag.
    always_comb begin
        strobe_cyc = armed && hit;
        done       = strobe_cyc && last_digit;
    end
endmodule

// File: rtl/bcd_digit_scanner.sv
// Top: stores a result on end-of-conversion and scans its digits onto a
// one-hot select and a shared BCD bus. It emits half-clock capture strobes on
// the first scan and blanks after the last strobe of an overrange result
// until ref_start. Assumes eoc and ref_start are single-cycle pulses.
module bcd_digit_scanner
    import dscan_pkg::*;
#(
    parameter int N    = 5,
    parameter int SLOT = 200,
    parameter int OFS  = 100
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           eoc,
    input  logic           ovr_in,
    input  logic [4*N-1:0] digits_in,
    input  logic           ref_start,
    output logic [N-1:0]   dsel,
    output logic [3:0]     bcd,
    output logic           strobe_n
);
    localparam int IW = $clog2(N);

    bcd_t              dig_q [N];
    logic              ovr_q;
    logic              blank;
    logic              restart;
    logic [IW-1:0]     idx;
    logic              active;
    logic              hit;
    logic              strobe_cyc;
    logic              done;
    logic              lit;

    assign restart = eoc || (blank && ref_start);
    assign lit     = active && !blank;

    // Store each digit of a new result.
    for (genvar k = 0; k < N; k++) begin : g_store
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dig_q[k] <= '0;
            end else if (eoc) begin
                dig_q[k] <= digits_in[4*k +: 4];
            end
        end
    end

    // Store the overrange flag of a new result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (eoc) begin
            ovr_q <= ovr_in;
        end
    end

    // Blank after the final strobe of an overrange result; release on ref_start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank <= 1'b0;
        end else if (eoc) begin
            blank <= 1'b0;
        end else if (blank && ref_start) begin
            blank <= 1'b0;
        end else if (done && ovr_q) begin
            blank <= 1'b1;
        end
    end

    dscan_timer #(.N(N), .SLOT(SLOT), .OFS(OFS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .hold    (blank),
        .idx     (idx),
        .active  (active),
        .hit     (hit)
    );

    dscan_strobe u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (eoc),
        .hit        (hit),
        .last_digit (idx == '0),
        .strobe_cyc (strobe_cyc),
        .done       (done)
    );

    // Decode the digit index into one select line per digit.
    for (genvar k = 0; k < N; k++) begin : g_sel
        assign dsel[k] = lit && (idx == IW'(k));
    end

    // Put the selected digit on the bus; zero when dark or overrange.
    always_comb begin
        bcd = '0;
        if (lit && !ovr_q) begin
            bcd = dig_q[idx];
        end
    end

    // Pull the strobe low in the low phase of the strobe cycle.
    always_comb begin
        strobe_n = !(strobe_cyc && !clk);
    end
endmodule

// File: rtl/bcd_digit_scanner_chk.sv
// Checker for the digit scanner: port-level properties of select order,
// bus blanking, restart and overrange data. Attached by bind below.
module bcd_digit_scanner_chk #(
    parameter int N = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         eoc,
    input logic         ovr_in,
    input logic         ref_start,
    input logic [N-1:0] dsel,
    input logic [3:0]   bcd
);
    localparam logic [N-1:0] TOP = {1'b1, {(N-1){1'b0}}};

    // R1: reset leaves the outputs dark.
    a_r1_reset_dark: assert property (@(posedge clk)
        !rst_n |=> (dsel == '0 && bcd == '0));

    // R3: never more than one select line.
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dsel));

    // R2: a stored result starts on the top digit.
    a_r2_start_top: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> dsel == TOP);

    // R3: the select holds, steps down by one, wraps, or goes dark.
    a_r3_step_order: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel != '0 && !eoc && !ref_start) |=>
        (dsel == '0 || $stable(dsel) || dsel == ($past(dsel) >> 1)
         || ($past(dsel) == {{(N-1){1'b0}}, 1'b1} && dsel == TOP)));

    // R5: no select, no data.
    a_r5_dark_bus: assert property (@(posedge clk) disable iff (!rst_n)
        dsel == '0 |-> bcd == '0);

    // R9: an overrange result reads zero on the bus.
    a_r9_ovr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && ovr_in) |=> bcd == '0);
endmodule

bind bcd_digit_scanner bcd_digit_scanner_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eoc       (eoc),
    .ovr_in    (ovr_in),
    .ref_start (ref_start),
    .dsel      (dsel),
    .bcd       (bcd)
);

// File: tb/tb_bcd_digit_scanner.sv
// Scoreboard bench: driver tasks push expected per-cycle items, the monitor
// pops one per cycle in the clock low phase and compares.
module tb_bcd_digit_scanner;
    localparam int SLOT  = 200;
    localparam int OFS   = 100;
    localparam int SCAN  = SLOT + 1 + 4 * SLOT;
    localparam int LASTS = SLOT + 1 + 3 * SLOT + OFS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eoc = 1'b0;
    logic        ovr_in = 1'b0;
    logic [19:0] digits_in = '0;
    logic        ref_start = 1'b0;
    logic [4:0]  dsel;
    logic [3:0]  bcd;
    logic        strobe_n;

    int nvec = 0;
    int nfail = 0;
    bit ended = 1'b0;
    logic [9:0] q_exp [$];
    string      q_tag [$];

    always #10 clk = ~clk;

    bcd_digit_scanner dut (
        .clk(clk), .rst_n(rst_n), .eoc(eoc), .ovr_in(ovr_in),
        .digits_in(digits_in), .ref_start(ref_start),
        .dsel(dsel), .bcd(bcd), .strobe_n(strobe_n)
    );

    task automatic push_idle(input int n, input string tag);
        for (int c = 0; c < n; c++) begin
            q_exp.push_back(10'b0);
            q_tag.push_back(tag);
        end
    endtask

    // Expected trace from a scan start: slot lengths, strobe spots, blanking.
    task automatic push_scan(input logic [19:0] d, input bit ovr, input bit first,
                             input int n, input string tag);
        for (int c = 0; c < n; c++) begin
            int p;
            int dig;
            int off;
            int spot;
            bit blk;
            bit stb;
            logic [4:0] ds;
            logic [3:0] bc;
            p = c % SCAN;
            if (p < SLOT + 1) begin
                dig = 5; off = p; spot = OFS + 1;
            end else begin
                dig = 4 - (p - SLOT - 1) / SLOT;
                off = (p - SLOT - 1) % SLOT;
                spot = OFS;
            end
            blk = ovr && first && (c > LASTS);
            stb = first && (c < SCAN) && (off == spot) && !blk;
            ds  = blk ? 5'b0 : 5'(1 << (dig - 1));
            bc  = (blk || ovr) ? 4'b0 : d[(dig-1)*4 +: 4];
            q_exp.push_back({ds, bc, stb});
            q_tag.push_back(tag);
        end
    endtask

    task automatic conv(input logic [19:0] d, input bit ovr);
        @(posedge clk); #2;
        digits_in = d; ovr_in = ovr; eoc = 1'b1;
        @(posedge clk); #2;
        eoc = 1'b0;
    endtask

    task automatic kick_ref();
        @(posedge clk); #2;
        ref_start = 1'b1;
        @(posedge clk); #2;
        ref_start = 1'b0;
    endtask

    task automatic drain();
        wait (q_exp.size() == 0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    // Monitor: compare one expected item per cycle in the low phase.
    initial begin
        forever begin
            @(posedge clk); #15;
            if (q_exp.size() > 0) begin
                logic [9:0] e;
                string t;
                bit bad;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                bad = 1'b0;
                nvec++;
                if (dsel !== e[9:5]) begin
                    $display("FAIL %s dsel actual=%b expected=%b", t, dsel, e[9:5]);
                    bad = 1'b1;
                end
                if (bcd !== e[4:1]) begin
                    $display("FAIL %s bcd actual=%h expected=%h", t, bcd, e[4:1]);
                    bad = 1'b1;
                end
                if (strobe_n !== !e[0]) begin
                    $display("FAIL %s strobe_n actual=%b expected=%b", t, strobe_n, !e[0]);
                    bad = 1'b1;
                end
                if (bad) nfail++;
            end
        end
    end

    // Driver: stimulus sequence by requirement.
    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        push_idle(5, "R1");                       // R1 dark until first result
        drain();

        conv(20'h12345, 1'b0);                    // R2 R3 R4 R5 R6 R7
        push_scan(20'h12345, 1'b0, 1'b1, 2 * SCAN + 50, "R2/R3/R4/R5/R6/R7");
        drain();

        conv(20'h98760, 1'b0);                    // R5 R6 second pattern
        push_scan(20'h98760, 1'b0, 1'b1, SCAN, "R5/R6");
        drain();

        conv(20'h24680, 1'b0);                    // R8 restart mid-scan
        push_scan(20'h24680, 1'b0, 1'b1, 450, "R8");
        drain();
        conv(20'h13579, 1'b0);
        push_scan(20'h13579, 1'b0, 1'b1, SCAN, "R8");
        drain();

        conv(20'h31415, 1'b0);                    // R11 ignored ref_start
        push_scan(20'h31415, 1'b0, 1'b1, SCAN, "R11");
        repeat (300) @(posedge clk);
        #2 ref_start = 1'b1;
        @(posedge clk);
        #2 ref_start = 1'b0;
        drain();

        conv(20'h19999, 1'b1);                    // R9 R10 overrange blanking
        push_scan(20'h19999, 1'b1, 1'b1, SCAN + 100, "R9/R10");
        drain();
        kick_ref();
        push_scan(20'h19999, 1'b1, 1'b0, SCAN, "R10");
        drain();

        conv(20'h54321, 1'b0);                    // R9 cleared by a new result
        push_scan(20'h54321, 1'b0, 1'b1, 300, "R9");
        drain();

        @(posedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        finish_run();
    end
endmodule